// File: doc/BRIEF.md
# Backup Power Sequencer

This block moves a device between three operating conditions: normal running, held in reset with clocks alive, and a low-power backup condition. It watches two asynchronous pins: an active-high power-enable and an active-low reset. Its outputs are clock and PLL enables, an internal active-low reset and a set of pad-parking controls. It runs on the always-on slow timer clock, which is the only clock that keeps running in backup. For that reason every timing decision in the block is counted in slow-clock cycles.

In backup the main clock enable and the PLL enable are both low. Memories therefore keep their contents, because nothing clocks them. Each pad class is parked at a defined level: the buses and general-purpose ports are tri-stated, the select and strobe outputs are held high, and the serial transmit and clock outputs are held low.

Power-enable must rise first to leave backup. The PLL is then enabled, and a settling counter covers oscillator start-up plus PLL lock. Only after that count completes, and once the reset pin is high, is the internal reset released. While the device is running, a low pulse on the reset pin takes effect only if it lasts a minimum width. If power-enable is high at that point, the device goes to reset. If power-enable is low, it goes to backup.

Top module: `bkp_power_seq`

## Requirements
- R1: After the asynchronous reset, the block is in backup: `pad_mode_o` is 2'b10, and `main_clk_en_o`, `pll_en_o` and `int_rst_n_o` are all 0.
- R2: `park_hiz_o`, `park_strb_hi_o` and `park_txclk_lo_o` are all 1 whenever `pad_mode_o` is 2'b10 (backup). All three are 0 in any other mode.
- R3: After `pwr_en_i` rises in backup, `pll_en_o` goes to 1. `main_clk_en_o` then stays 0 for exactly `SETTLE_CYCLES` cycles of `pll_en_o` high before it rises. `pad_mode_o` reads 2'b01 (reset) during this time.
- R4: `int_rst_n_o` stays 0 until the settling count is complete, even if the reset pin was released earlier. It rises only once `main_clk_en_o` is 1 and the synchronized reset pin is high.
- R5: When the reset pin goes high with clocks running, the block enters normal mode. In normal mode `int_rst_n_o`, `main_clk_en_o` and `pll_en_o` are 1 and `pad_mode_o` is 2'b00.
- R6: In normal mode, a low pulse on `rst_pin_n_i` that lasts fewer than `MIN_PULSE_CYCLES` cycles has no effect on any output.
- R7: In normal mode, a low level on `rst_pin_n_i` that lasts at least `MIN_PULSE_CYCLES` cycles, with `pwr_en_i` high, puts the block in reset mode. In reset mode `int_rst_n_o` is 0, both enables are 1 and `pad_mode_o` is 2'b01. The block returns to normal when the pin goes high.
- R8: In normal mode, a low level on `rst_pin_n_i` that lasts at least `MIN_PULSE_CYCLES` cycles, with `pwr_en_i` low, puts the block in backup.
- R9: While settling or in reset mode, both pins low together abort to backup.
- R10: In normal mode, `pwr_en_i` going low while the reset pin stays high has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow timer clock |
| rst_n | input | 1 | Power-on reset, asynchronous assert, active low |
| pwr_en_i | input | 1 | Power-enable pin, asynchronous, active high |
| rst_pin_n_i | input | 1 | Reset pin, asynchronous, active low |
| main_clk_en_o | output | 1 | Enable for the main (CPU and bus) clock |
| pll_en_o | output | 1 | Enable for the PLL and main oscillator |
| int_rst_n_o | output | 1 | Internal reset for registers, active low |
| pad_mode_o | output | 2 | 00 normal, 01 reset, 10 backup |
| park_hiz_o | output | 1 | Tri-state data, address and port pads |
| park_strb_hi_o | output | 1 | Drive chip selects, write and read strobes high |
| park_txclk_lo_o | output | 1 | Drive serial transmit and clock output pads low |

## Verification
The assertions assume that both pins are held stable for at least two slow-clock cycles around each change. This lets every level reach the synchronizers. The bench drives the pins only on the falling clock edge and holds each level for whole cycles. The assertions also assume that the power-up rule (reset pin released long after power-enable) is met by the environment rather than checked by the block. The bench sweeps reset-pin pulse widths across the qualification threshold, and it releases the reset pin both before and after settling completes.

// File: rtl/bkp_pkg.sv
package bkp_pkg;
  typedef enum logic [1:0] {
    PAD_NORMAL = 2'b00,
    PAD_RESET  = 2'b01,
    PAD_BACKUP = 2'b10
  } pad_mode_e;

  typedef enum logic [1:0] {
    ST_BACKUP = 2'b00,
    ST_SETTLE = 2'b01,
    ST_HOLD   = 2'b10,
    ST_RUN    = 2'b11
  } seq_state_e;
endpackage

// File: rtl/bkp_sync2.sv
module bkp_sync2 #(
  parameter int unsigned          WIDTH   = 1,
  parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q;
    logic sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= d[i];
        sync_q <= meta_q;
      end
    end
    assign q[i] = sync_q;
  end
endmodule

// File: rtl/bkp_settle_timer.sv
module bkp_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)             cnt_d = '0;
    else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/bkp_pulse_qual.sv
module bkp_pulse_qual #(
  parameter int unsigned MIN_PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic pin_low_i,
  output logic qual_o
);
  localparam int unsigned CW = $clog2(MIN_PULSE_CYCLES + 1);
  localparam logic [CW-1:0] TOP = CW'(MIN_PULSE_CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!arm_i || !pin_low_i) cnt_d = '0;
    else if (cnt_q != TOP)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign qual_o = arm_i && (cnt_q == TOP);
endmodule

// File: rtl/bkp_pad_decode.sv
module bkp_pad_decode
  import bkp_pkg::*;
(
  input  seq_state_e state_i,
  output logic       main_clk_en_o,
  output logic       pll_en_o,
  output logic       int_rst_n_o,
  output logic [1:0] pad_mode_o,
  output logic       park_hiz_o,
  output logic       park_strb_hi_o,
  output logic       park_txclk_lo_o
);
  pad_mode_e mode;

  always_comb begin
    main_clk_en_o = 1'b0;
    pll_en_o      = 1'b0;
    int_rst_n_o   = 1'b0;
    mode          = PAD_BACKUP;
    unique case (state_i)
      ST_BACKUP: begin
        mode = PAD_BACKUP;
      end
      ST_SETTLE: begin
        pll_en_o = 1'b1;
        mode     = PAD_RESET;
      end
      ST_HOLD: begin
        pll_en_o      = 1'b1;
        main_clk_en_o = 1'b1;
        mode          = PAD_RESET;
      end
      ST_RUN: begin
        pll_en_o      = 1'b1;
        main_clk_en_o = 1'b1;
        int_rst_n_o   = 1'b1;
        mode          = PAD_NORMAL;
      end
      default: mode = PAD_BACKUP;
    endcase
  end

  assign pad_mode_o      = mode;
  assign park_hiz_o      = (mode == PAD_BACKUP);
  assign park_strb_hi_o  = (mode == PAD_BACKUP);
  assign park_txclk_lo_o = (mode == PAD_BACKUP);
endmodule

// File: rtl/bkp_power_seq.sv
module bkp_power_seq
  import bkp_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES    = 64,
  parameter int unsigned MIN_PULSE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_en_i,
  input  logic       rst_pin_n_i,
  output logic       main_clk_en_o,
  output logic       pll_en_o,
  output logic       int_rst_n_o,
  output logic [1:0] pad_mode_o,
  output logic       park_hiz_o,
  output logic       park_strb_hi_o,
  output logic       park_txclk_lo_o
);
  // Reset: asynchronous assertion, release aligned to clk.
  logic rst_sync_n;
  bkp_sync2 #(.WIDTH(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  // Pin synchronizers: bit 1 = power enable, bit 0 = reset pin.
  logic [1:0] pins_s;
  bkp_sync2 #(.WIDTH(2), .RST_VAL(2'b00)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({pwr_en_i, rst_pin_n_i}),
    .q     (pins_s)
  );

  logic pwr_s;
  logic pin_n_s;
  assign pwr_s   = pins_s[1];
  assign pin_n_s = pins_s[0];

  seq_state_e state_q;
  seq_state_e state_d;
  logic       settle_done;
  logic       pulse_qual;
  logic       both_low;

  assign both_low = !pwr_s && !pin_n_s;

  bkp_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run_i  (state_q == ST_SETTLE),
    .done_o (settle_done)
  );

  bkp_pulse_qual #(.MIN_PULSE_CYCLES(MIN_PULSE_CYCLES)) u_qual (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .arm_i     (state_q == ST_RUN),
    .pin_low_i (!pin_n_s),
    .qual_o    (pulse_qual)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_BACKUP: if (pwr_s)                state_d = ST_SETTLE;
      ST_SETTLE: if (both_low)             state_d = ST_BACKUP;
                 else if (settle_done)     state_d = ST_HOLD;
      ST_HOLD:   if (both_low)             state_d = ST_BACKUP;
                 else if (pin_n_s)         state_d = ST_RUN;
      ST_RUN:    if (pulse_qual)           state_d = pwr_s ? ST_HOLD : ST_BACKUP;
      default:                             state_d = ST_BACKUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_BACKUP;
    else             state_q <= state_d;
  end

  bkp_pad_decode u_decode (
    .state_i         (state_q),
    .main_clk_en_o   (main_clk_en_o),
    .pll_en_o        (pll_en_o),
    .int_rst_n_o     (int_rst_n_o),
    .pad_mode_o      (pad_mode_o),
    .park_hiz_o      (park_hiz_o),
    .park_strb_hi_o  (park_strb_hi_o),
    .park_txclk_lo_o (park_txclk_lo_o)
  );
endmodule

// File: rtl/bkp_power_seq_chk.sv
module bkp_power_seq_chk #(
  parameter int unsigned SETTLE_CYCLES = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       main_clk_en_o,
  input logic       pll_en_o,
  input logic       int_rst_n_o,
  input logic [1:0] pad_mode_o,
  input logic       park_hiz_o,
  input logic       park_strb_hi_o,
  input logic       park_txclk_lo_o
);
  int unsigned settle_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              settle_seen <= 0;
    else if (!pll_en_o)      settle_seen <= 0;
    else if (!main_clk_en_o) settle_seen <= settle_seen + 1;
  end

  // R2: pads parked exactly in backup, with PLL off
  a_r2_park_in_backup: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_mode_o == 2'b10) |-> (park_hiz_o && park_strb_hi_o && park_txclk_lo_o && !pll_en_o));
  a_r2_free_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_mode_o != 2'b10) |-> !(park_hiz_o || park_strb_hi_o || park_txclk_lo_o));
  // R3: main clock only with PLL, and only after the full settle window
  a_r3_clk_needs_pll: assert property (@(posedge clk) disable iff (!rst_n)
    main_clk_en_o |-> pll_en_o);
  a_r3_settle_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_clk_en_o) |-> (settle_seen == SETTLE_CYCLES));
  // R4: internal reset released only with clocks running
  a_r4_release_order: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst_n_o |-> (main_clk_en_o && pll_en_o));
  // R7: reset pad mode keeps internal reset asserted
  a_r7_reset_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_mode_o == 2'b01) |-> !int_rst_n_o);
  // R5: normal pad mode only with internal reset released
  a_r5_normal_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_mode_o == 2'b00) |-> int_rst_n_o);
endmodule

bind bkp_power_seq bkp_power_seq_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .main_clk_en_o   (main_clk_en_o),
  .pll_en_o        (pll_en_o),
  .int_rst_n_o     (int_rst_n_o),
  .pad_mode_o      (pad_mode_o),
  .park_hiz_o      (park_hiz_o),
  .park_strb_hi_o  (park_strb_hi_o),
  .park_txclk_lo_o (park_txclk_lo_o)
);

// File: tb/bkp_power_seq_bench.sv
`timescale 1ns/1ps
module bkp_power_seq_bench;
  localparam int SETTLE = 12;
  localparam int MINP   = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic pwr_en;
  logic rst_pin_n;
  logic main_clk_en, pll_en, int_rst_n;
  logic [1:0] pad_mode;
  logic park_hiz, park_strb, park_txclk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  bkp_power_seq #(.SETTLE_CYCLES(SETTLE), .MIN_PULSE_CYCLES(MINP)) u_bkp_power_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .pwr_en_i        (pwr_en),
    .rst_pin_n_i     (rst_pin_n),
    .main_clk_en_o   (main_clk_en),
    .pll_en_o        (pll_en),
    .int_rst_n_o     (int_rst_n),
    .pad_mode_o      (pad_mode),
    .park_hiz_o      (park_hiz),
    .park_strb_hi_o  (park_strb),
    .park_txclk_lo_o (park_txclk)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Packs outputs as {pad_mode, main_clk_en, pll_en, int_rst_n, parks(3)}
  function automatic int outs();
    return {pad_mode, main_clk_en, pll_en, int_rst_n, park_hiz, park_strb, park_txclk};
  endfunction

  localparam int O_BACKUP = {2'b10, 1'b0, 1'b0, 1'b0, 3'b111};
  localparam int O_RESET  = {2'b01, 1'b1, 1'b1, 1'b0, 3'b000};
  localparam int O_NORMAL = {2'b00, 1'b1, 1'b1, 1'b1, 3'b000};

  // From backup: raise power enable and count the settle window at the ports.
  task automatic wake(input string req);
    int n = 0;
    int guard = 0;
    pwr_en = 1'b1;
    while (!pll_en && guard < 20) begin cyc(1); guard++; end
    chk({req, " pll on"}, pll_en, 1);
    while (pll_en && !main_clk_en && n < 4 * SETTLE) begin
      chk({req, " reset pads while settling"}, pad_mode, 1);
      chk({req, " internal reset held"}, int_rst_n, 0);
      cyc(1); n++;
    end
    chk({req, " settle cycles"}, n, SETTLE);
  endtask

  task automatic to_normal();
    pwr_en = 1'b1; rst_pin_n = 1'b1;
    for (int g = 0; g < 4 * SETTLE + 20 && outs() != O_NORMAL; g++) cyc(1);
  endtask

  initial begin
    rst_n = 1'b0; pwr_en = 1'b0; rst_pin_n = 1'b0;
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    chk("R1 reset state", outs(), O_BACKUP);
    chk("R2 parks in backup", {park_hiz, park_strb, park_txclk}, 7);

    // R3/R4: pin held low through settling, released afterwards
    wake("R3");
    cyc(6);
    chk("R4 pin low keeps reset", outs(), O_RESET);
    chk("R2 no parks in reset", {park_hiz, park_strb, park_txclk}, 0);
    rst_pin_n = 1'b1;
    cyc(4);
    chk("R5 normal after release", outs(), O_NORMAL);

    // R6/R7: sweep reset pulse widths across the threshold
    for (int w = 1; w <= MINP + 3; w++) begin
      int saw_reset = 0;
      rst_pin_n = 1'b0;
      for (int k = 0; k < w; k++) begin
        cyc(1);
        if (!int_rst_n) saw_reset = 1;
      end
      rst_pin_n = 1'b1;
      for (int k = 0; k < MINP + 8; k++) begin
        if (!int_rst_n) saw_reset = 1;
        if (outs() == O_RESET) chk("R7 reset mode outputs", outs(), O_RESET);
        cyc(1);
      end
      if (w < MINP) chk($sformatf("R6 short pulse w=%0d ignored", w), saw_reset, 0);
      else          chk($sformatf("R7 long pulse w=%0d taken", w), saw_reset, 1);
      chk("R7 back to normal", outs(), O_NORMAL);
    end

    // R10: power enable low alone has no effect
    pwr_en = 1'b0;
    cyc(15);
    chk("R10 pwr low alone ignored", outs(), O_NORMAL);

    // R8: qualified reset with power enable low enters backup
    rst_pin_n = 1'b0;
    cyc(MINP + 6);
    chk("R8 backup entry", outs(), O_BACKUP);

    // R4: pin released before settling completes
    rst_pin_n = 1'b1;
    cyc(3);
    chk("R8 backup holds with pin high", outs(), O_BACKUP);
    wake("R4 early release");
    cyc(4);
    chk("R4 released after settle", outs(), O_NORMAL);

    // R9: abort during settling
    rst_pin_n = 1'b0; pwr_en = 1'b0;
    cyc(MINP + 6);
    chk("R8 backup again", outs(), O_BACKUP);
    pwr_en = 1'b1;
    cyc(5);
    chk("R9 settling", pll_en && !main_clk_en, 1);
    pwr_en = 1'b0;
    cyc(4);
    chk("R9 abort settle to backup", outs(), O_BACKUP);

    // R9: abort from reset mode
    wake("R9 rewake");
    cyc(3);
    chk("R9 in reset mode", outs(), O_RESET);
    pwr_en = 1'b0;
    cyc(4);
    chk("R9 abort reset to backup", outs(), O_BACKUP);

    to_normal();
    chk("R5 final normal", outs(), O_NORMAL);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule